// File: doc/BRIEF.md
# Bidirectional Read/Write Bus Buffer

This block sits between a fast host bus (side A) and a slower memory or peripheral bus (side B), 18 bits wide by default. Traffic from A to B, the write direction, is queued in a four-entry synchronous FIFO. The host can post writes without waiting for the slow side. Traffic from B to A, the read direction, passes through one transparent latch. The latch holds a returned word steady for the host.

The FIFO runs on one clock. It has two active-low request pins, one for pushing and one for popping, and an active-low full flag. A request that the FIFO cannot honour is dropped. Nothing is stalled and no error is raised: a push into a full FIFO is discarded, and a pop from an empty FIFO leaves the output word unchanged. The control logic upstream must read the full flag before it pushes.

The FIFO output is a register. It changes only on an accepted pop or on reset, and reset sets it to all ones. Each side has an active-low drive request. The pads are modelled as separate in, out and output-enable signals.

Top module: `rwbuf_top`

## Requirements
- R1: Each clock edge where `push_n` is low and the FIFO is not full stores `a_in` at the tail of the FIFO. Words leave the FIFO in the same order they were stored.
- R2: Each clock edge where `pop_n` is low and the FIFO is not empty loads the oldest stored word into the FIFO output register and removes that word from the FIFO. Between accepted pops the output register keeps its value.
- R3: `full_n` is low exactly when four words are stored. It is high after reset.
- R4: A push on an edge where the FIFO is full is discarded. Both the stored words and the count are unchanged.
- R5: A pop on an edge where the FIFO is empty has no effect. The output register keeps the last word it held.
- R6: On a clock edge with `rst_n` low, the FIFO becomes empty and the output register becomes all ones. This happens whatever `push_n` and `pop_n` are doing.
- R7: A push and a pop on the same edge, with the FIFO neither empty nor full, are both carried out. The count does not change.
- R8: A push and a pop on the same edge with the FIFO empty perform only the push. The output register keeps its value.
- R9: A push and a pop on the same edge with the FIFO full perform only the pop. The pushed word is discarded and `full_n` goes high.
- R10: While `le` is high, the read latch passes `b_in` through to side A.
- R11: When `le` falls, the latch captures `b_in`. It keeps that value while `le` stays low, whatever `b_in` does.
- R12: When `b_drv_n` is low, `b_oe` is 1 and `b_out` carries the FIFO output register. When `a_drv_n` is low, `a_oe` is 1 and `a_out` carries the latch value. When a drive request is high, the matching enable is 0 and the matching data output is held at zero.
- R13: Activity on the read path (`le`, `b_in`, `a_drv_n`) does not change what the FIFO stores or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO clock, rising edge |
| rst_n | input | 1 | Synchronous FIFO reset, active low |
| push_n | input | 1 | Push request into the FIFO, active low |
| pop_n | input | 1 | Pop request from the FIFO, active low |
| full_n | output | 1 | FIFO full flag, low when four words are stored |
| le | input | 1 | Read latch enable, transparent while high |
| a_drv_n | input | 1 | Side A drive request, active low |
| b_drv_n | input | 1 | Side B drive request, active low |
| a_in | input | W | Side A pad input, data pushed into the FIFO |
| a_out | output | W | Side A pad output, the latch value |
| a_oe | output | 1 | Side A pad output enable |
| b_in | input | W | Side B pad input, data into the read latch |
| b_out | output | W | Side B pad output, the FIFO output register |
| b_oe | output | 1 | Side B pad output enable |

## Verification
The bench keeps a reference queue and drives the FIFO around its boundaries:
- **Pushing into a full FIFO.** A design that did not drop the fifth push would overwrite the oldest word, and the drain would return the wrong sequence.
- **Popping an empty FIFO.** A design that did not ignore the pop would move the output to a stale or unwritten entry.
- **Simultaneous push and pop at zero and at four entries.** A design that let the illegal half through would corrupt the count, and the full flag or the drain order would go wrong.
- **Reset while both requests are active.** A design that gave the requests priority over reset would leave a word behind, or an output other than all ones.

On the read side, the bench moves `b_in` after `le` has fallen. A latch that tracked `b_in` while closed, or captured on the wrong edge, would show the new value on `a_out`.

// File: rtl/rwbuf_pkg.sv
package rwbuf_pkg;
  // Outcome of one FIFO clock edge after the boundary rules are applied
  typedef struct packed {
    logic do_push;
    logic do_pop;
  } fifo_act_t;

  // Boundary rule: a push needs room, a pop needs a stored word
  function automatic fifo_act_t resolve(input logic want_push, input logic want_pop,
                                        input logic is_full, input logic is_empty);
    fifo_act_t r;
    r.do_push = want_push && !is_full;
    r.do_pop  = want_pop && !is_empty;
    return r;
  endfunction
endpackage

// File: rtl/rwbuf_fifo.sv
module rwbuf_fifo
  import rwbuf_pkg::*;
#(
  parameter int W = 18,
  parameter int D = 4   // power of two so the pointers wrap naturally
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wdata,
  input  logic         push,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (D > 1) ? $clog2(D) : 1;
  localparam int CW = $clog2(D + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(D);

  logic [W-1:0]  store [D];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  fifo_act_t     act;

  assign full  = (cnt == CNT_MAX);
  assign empty = (cnt == '0);
  assign act   = resolve(push, pop, full, empty);

  always_ff @(posedge clk) begin
    if (act.do_push) store[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      rdata <= '1;
    end else begin
      if (act.do_push) wp <= wp + 1'b1;
      if (act.do_pop) begin
        rdata <= store[rp];
        rp    <= rp + 1'b1;
      end
      case ({act.do_push, act.do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_MAX);
  // R4
  full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> (full && $stable(wp)));
  // R5
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> ($stable(rdata) && empty));
  // R6
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (empty && rdata == '1));
  // R8
  empty_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && empty) |=> (cnt == CW'(1) && $stable(rdata)));
  // R9
  full_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && full) |=> (cnt == CNT_MAX - 1'b1));
endmodule

// File: rtl/rwbuf_rdlatch.sv
module rwbuf_rdlatch #(
  parameter int W = 18
) (
  input  logic         clk,    // observation only, for the hold check
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_latch begin
    if (le) q <= din;
  end

  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && $past(!le)) |-> $stable(q));
endmodule

// File: rtl/rwbuf_drive.sv
module rwbuf_drive #(
  parameter int W = 18
) (
  input  logic         drv_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] pad_out,
  output logic         pad_oe
);
  assign pad_oe  = ~drv_n;
  assign pad_out = drv_n ? '0 : src;
endmodule

// File: rtl/rwbuf_top.sv
module rwbuf_top #(
  parameter int W = 18,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_n,
  input  logic         pop_n,
  output logic         full_n,
  input  logic         le,
  input  logic         a_drv_n,
  input  logic         b_drv_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] fifo_q, latch_q;
  logic         is_full, is_empty;

  rwbuf_fifo #(.W(W), .D(D)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wdata(a_in),
    .push(~push_n), .pop(~pop_n),
    .rdata(fifo_q), .full(is_full), .empty(is_empty)
  );

  rwbuf_rdlatch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .le(le), .din(b_in), .q(latch_q)
  );

  rwbuf_drive #(.W(W)) u_drv_b (
    .drv_n(b_drv_n), .src(fifo_q), .pad_out(b_out), .pad_oe(b_oe)
  );

  rwbuf_drive #(.W(W)) u_drv_a (
    .drv_n(a_drv_n), .src(latch_q), .pad_out(a_out), .pad_oe(a_oe)
  );

  assign full_n = ~is_full;

  // R3
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_empty |-> full_n);
endmodule

// File: tb/rwbuf_top_test.sv
module rwbuf_top_test;
  localparam int W = 18;

  logic clk = 0, rst_n = 0, push_n = 1, pop_n = 1, le = 1;
  logic a_drv_n = 0, b_drv_n = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, full_n;

  int checks = 0, fails = 0;
  logic [W-1:0] mq[$];
  logic [W-1:0] exp_q;

  always #10 clk = ~clk;

  rwbuf_top #(.W(W), .D(4)) uut (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .pop_n(pop_n), .full_n(full_n),
    .le(le), .a_drv_n(a_drv_n), .b_drv_n(b_drv_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock with the given requests. Inputs change at the falling edge;
  // results are sampled at the next falling edge.
  task automatic step(input logic wn, input logic rn, input logic [W-1:0] d, input string tag);
    int n;
    logic dw, dr;
    push_n = wn; pop_n = rn; a_in = d;
    n  = mq.size();
    dw = !wn && n < 4;
    dr = !rn && n > 0;
    if (dr) exp_q = mq.pop_front();
    if (dw) mq.push_back(d);
    @(negedge clk);
    push_n = 1; pop_n = 1;
    check({tag, " data"}, b_out, exp_q);
    check({tag, " full_n"}, W'(full_n), W'(mq.size() != 4));
  endtask

  task automatic do_reset(input string tag);
    rst_n = 0; push_n = 0; pop_n = 0; a_in = 18'h2AAAA;
    @(negedge clk);
    rst_n = 1; push_n = 1; pop_n = 1;
    mq.delete(); exp_q = '1;
    check({tag, " output all ones"}, b_out, '1);
    check({tag, " full_n high"}, W'(full_n), W'(1));
  endtask

  task automatic t_reset();
    step(0, 1, 18'h00011, "R1 pre-reset push");
    do_reset("R6");
    step(1, 0, 18'h0, "R5 pop after reset (empty)");
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < 4; i++) step(0, 1, 18'h10000 + W'(i), "R1 fill");
    check("R3 full after four", W'(full_n), W'(0));
    step(0, 1, 18'h3FFF0, "R4 push while full");
    for (int i = 0; i < 4; i++) step(1, 0, 18'h0, "R2 drain order");
    step(1, 0, 18'h0, "R5 pop while empty");
    for (int i = 0; i < 3; i++) step(1, 1, 18'h0, "R2 hold between pops");
  endtask

  task automatic t_simul_mid();
    step(0, 1, 18'h0A001, "R1 push");
    step(0, 1, 18'h0A002, "R1 push");
    for (int i = 0; i < 3; i++) step(0, 0, 18'h0B000 + W'(i), "R7 push and pop");
    step(1, 0, 18'h0, "R7 drain");
    step(1, 0, 18'h0, "R7 drain");
    step(1, 0, 18'h0, "R5 empty again");
  endtask

  task automatic t_simul_empty();
    step(0, 0, 18'h0C0DE, "R8 both at empty");
    step(1, 0, 18'h0, "R8 word pops later");
  endtask

  task automatic t_simul_full();
    for (int i = 0; i < 4; i++) step(0, 1, 18'h2F000 + W'(i), "R1 fill");
    step(0, 0, 18'h1DEAD, "R9 both at full");
    for (int i = 0; i < 4; i++) step(1, 0, 18'h0, "R9 drain");
  endtask

  task automatic t_latch();
    a_drv_n = 0; le = 1; b_in = 18'h12345; #3;
    check("R10 transparent", a_out, 18'h12345);
    b_in = 18'h0F0F0; #3;
    check("R10 follows input", a_out, 18'h0F0F0);
    le = 0; #3;
    b_in = 18'h33333; #3;
    check("R11 holds after fall", a_out, 18'h0F0F0);
    @(negedge clk); @(negedge clk);
    b_in = 18'h00001; #3;
    check("R11 still held", a_out, 18'h0F0F0);
    le = 1; #3;
    check("R10 reopens", a_out, 18'h00001);
  endtask

  task automatic t_oe();
    step(0, 1, 18'h15A5A, "R1 push");
    step(1, 0, 18'h0, "R2 pop");
    b_drv_n = 1; a_drv_n = 1; #3;
    check("R12 b_oe off", W'(b_oe), W'(0));
    check("R12 b_out zero", b_out, '0);
    check("R12 a_oe off", W'(a_oe), W'(0));
    check("R12 a_out zero", a_out, '0);
    b_drv_n = 0; a_drv_n = 0; #3;
    check("R12 b_oe on", W'(b_oe), W'(1));
    check("R12 b_out data", b_out, 18'h15A5A);
    check("R12 a_oe on", W'(a_oe), W'(1));
    check("R12 a_out latch", a_out, 18'h00001);
  endtask

  task automatic t_indep();
    step(0, 1, 18'h07777, "R13 push");
    le = 1; b_in = 18'h3C3C3; a_drv_n = 1;
    step(0, 1, 18'h08888, "R13 push with read path busy");
    le = 0; b_in = 18'h00000; a_drv_n = 0;
    step(1, 0, 18'h0, "R13 pop");
    b_in = 18'h3FFFF;
    step(1, 0, 18'h0, "R13 pop");
    check("R11 latch kept through FIFO traffic", a_out, 18'h3C3C3);
    le = 1;
  endtask

  initial begin
    exp_q = '1;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    check("R6 reset output", b_out, '1);
    check("R3 reset full_n", W'(full_n), W'(1));
    t_reset();
    t_fill_drain();
    t_simul_mid();
    t_simul_empty();
    t_simul_full();
    t_latch();
    t_oe();
    t_indep();
    do_reset("R6 final");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule